// File: doc/BRIEF.md
# Masked Content-Addressable Memory Array

This block is a small synchronous associative store. It holds a parameterised number of words (16 by default), each 64 bits wide, in flip-flops. Every word carries a two-bit type code. A host loads a search key, and all words of type Valid are compared with it in parallel. The registered result gives a hit flag, a flag for more than one hit, and the index of the lowest hitting word. Each word is split into a compared field (the low lanes) and an associated field (the remaining upper lanes). On a hit, the associated field of the winning word is returned.

The host port is a single strobed cycle decoded from two active-low qualifiers. A command write selects an operation. Data writes that follow go to the target that the last command picked. Two reads return the status word or the associated data. Two mask registers can be selected, independently, to drop bits from a compare or to protect bits of a stored word during a write. A configuration command sets the mask selections and the number of compared 16-bit lanes.

Top module: `masked_cam`

## Requirements
- R1: After rst_ni is asserted, every word is Empty with zero contents, both masks are zero, no mask is selected, all lanes are compared, and the status and associated data read as zero.
- R2: A cycle counts only when strobe_i is high. wr_ni=0,cmd_ni=0 is a command write, wr_ni=0,cmd_ni=1 a data write, wr_ni=1,cmd_ni=0 a status read, and wr_ni=1,cmd_ni=1 an associated-data read. data_o is zero when no read is strobed.
- R3: Type codes are 00 Valid, 01 Empty, 10 Skip and 11 RAM-only. Only Valid words can hit.
- R4: A data write to the key register (command code 1) starts a compare. The status changes at the second rising edge after the write, and still shows the previous result before that edge.
- R5: Command code 5 reruns the compare with the current key, words and configuration.
- R6: Status bit 63 is the hit flag, bit 62 is the multi-hit flag, and the low index bits hold the lowest hitting index. With no hit, all three are zero.
- R7: The configuration command (code 7) sets the compare-mask selection in bits 21:20 (1 selects mask one, 2 selects mask two, other values select none). Set mask bits are then excluded from the compare.
- R8: The configuration command sets the write-mask selection in bits 23:22, with the same encoding. A word write (code 4, index in bits 11:8, type in bits 17:16) keeps the stored bits wherever the selected mask is set. Mask one and mask two are loaded by data writes after command codes 2 and 3.
- R9: Configuration bits 26:24 give the number of compared low 16-bit lanes (0 to 4; larger values count as 4). On a hit, the associated-data read returns the winning word with its compared lanes zeroed. On a miss it returns zero.
- R10: The status and associated data hold their values until the next compare or clear, even if words change in the meantime.
- R11: Command code 6 marks every word Empty, zeroes both masks, and zeroes the status and associated data.

Top module port list order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Host cycle qualifier |
| wr_ni | input | 1 | Low for a write cycle, high for a read |
| cmd_ni | input | 1 | Low for a command or status cycle, high for a data cycle |
| data_i | input | 64 | Command word or write data |
| data_o | output | 64 | Status word or associated data during reads, else zero |

## Verification
A wrong stored type or word inside the array shows at the ports only on the next compare that involves that word. It appears there as a wrong hit flag, a wrong index or wrong associated bits, two edges after the key is loaded. Mask and configuration faults are therefore exposed by comparing keys close to the stored words, with every lane count and mask selection in use. A fault in the status holding logic shows as a status that changes on a read with no compare in between.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    ET_VALID = 2'b00,
    ET_EMPTY = 2'b01,
    ET_SKIP  = 2'b10,
    ET_RAM   = 2'b11
  } etype_e;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_LD_KEY  = 4'd1,
    OP_LD_M1   = 4'd2,
    OP_LD_M2   = 4'd3,
    OP_LD_WORD = 4'd4,
    OP_SEARCH  = 4'd5,
    OP_CLEAR   = 4'd6,
    OP_CONFIG  = 4'd7
  } op_e;

  typedef enum logic [2:0] {
    TG_NONE,
    TG_KEY,
    TG_M1,
    TG_M2,
    TG_WORD
  } tgt_e;

  // command word field positions
  localparam int F_OP    = 0;
  localparam int F_ADDR  = 8;
  localparam int F_TYPE  = 16;
  localparam int F_CSEL  = 20;
  localparam int F_WSEL  = 22;
  localparam int F_LANES = 24;

  localparam logic [1:0] MSEL_ONE = 2'd1;
  localparam logic [1:0] MSEL_TWO = 2'd2;
endpackage

// File: rtl/cam_host_decode.sv
module cam_host_decode
  import cam_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          wr_ni,
  input  logic          cmd_ni,
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    type_i,
  output logic          ld_key_o,
  output logic          ld_m1_o,
  output logic          ld_m2_o,
  output logic          ld_word_o,
  output logic [AW-1:0] word_addr_o,
  output logic [1:0]    word_type_o,
  output logic          search_o,
  output logic          clear_o,
  output logic          cfg_wr_o,
  output logic          rd_stat_o,
  output logic          rd_data_o
);
  logic cmd_wr, dat_wr;
  tgt_e tgt_q;
  logic [AW-1:0] addr_q;
  logic [1:0] type_q;

  assign cmd_wr    = strobe_i & ~wr_ni & ~cmd_ni;
  assign dat_wr    = strobe_i & ~wr_ni &  cmd_ni;
  assign rd_stat_o = strobe_i &  wr_ni & ~cmd_ni;
  assign rd_data_o = strobe_i &  wr_ni &  cmd_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= TG_NONE;
      addr_q <= '0;
      type_q <= ET_EMPTY;
    end else if (cmd_wr) begin
      case (op_i)
        OP_LD_KEY: tgt_q <= TG_KEY;
        OP_LD_M1:  tgt_q <= TG_M1;
        OP_LD_M2:  tgt_q <= TG_M2;
        OP_LD_WORD: begin
          tgt_q  <= TG_WORD;
          addr_q <= addr_i;
          type_q <= type_i;
        end
        OP_CLEAR:  tgt_q <= TG_NONE;
        default:   tgt_q <= tgt_q;
      endcase
    end
  end

  assign search_o    = cmd_wr && (op_i == OP_SEARCH);
  assign clear_o     = cmd_wr && (op_i == OP_CLEAR);
  assign cfg_wr_o    = cmd_wr && (op_i == OP_CONFIG);
  assign ld_key_o    = dat_wr && (tgt_q == TG_KEY);
  assign ld_m1_o     = dat_wr && (tgt_q == TG_M1);
  assign ld_m2_o     = dat_wr && (tgt_q == TG_M2);
  assign ld_word_o   = dat_wr && (tgt_q == TG_WORD);
  assign word_addr_o = addr_q;
  assign word_type_o = type_q;
endmodule

// File: rtl/cam_store.sv
module cam_store
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clear_i,
  input  logic                           wr_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [1:0]                     type_i,
  input  logic [WIDTH-1:0]               data_i,
  input  logic [WIDTH-1:0]               protect_i,
  output logic [ENTRIES-1:0][WIDTH-1:0]  words_o,
  output logic [ENTRIES-1:0][1:0]        types_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = wr_i && (addr_i == AW'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words_o[e] <= '0;
        types_o[e] <= ET_EMPTY;
      end else if (clear_i) begin
        types_o[e] <= ET_EMPTY;
      end else if (sel) begin
        words_o[e] <= (words_o[e] & protect_i) | (data_i & ~protect_i);
        types_o[e] <= type_i;
      end
    end
  end
endmodule

// File: rtl/cam_match.sv
module cam_match
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][WIDTH-1:0] words_i,
  input  logic [ENTRIES-1:0][1:0]       types_i,
  input  logic [WIDTH-1:0]              key_i,
  input  logic [WIDTH-1:0]              care_i,
  output logic                          any_o,
  output logic                          multi_o,
  output logic [AW-1:0]                 addr_o
);
  logic [ENTRIES-1:0] hit;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit[e] = (types_i[e] == ET_VALID) &&
                    (((words_i[e] ^ key_i) & care_i) == '0);
  end

  assign any_o   = |hit;
  assign multi_o = |(hit & (hit - ENTRIES'(1)));

  always_comb begin
    addr_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) addr_o = AW'(i);
    end
  end
endmodule

// File: rtl/masked_cam.sv
module masked_cam
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  parameter int LANE_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             wr_ni,
  input  logic             cmd_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o
);
  localparam int LANES = WIDTH / LANE_W;
  localparam int AW    = $clog2(ENTRIES);
  localparam int LW    = $clog2(LANES + 1);

  logic ld_key, ld_m1, ld_m2, ld_word, search, clear, cfg_wr, rd_stat, rd_data;
  logic [AW-1:0] word_addr;
  logic [1:0] word_type;

  logic [WIDTH-1:0] key_q, m1_q, m2_q;
  logic [1:0] csel_q, wsel_q;
  logic [LW-1:0] lanes_q, lanes_eff;
  logic go_q;
  logic match_q, multi_q;
  logic [AW-1:0] addr_q;
  logic [WIDTH-1:0] assoc_q;

  logic [WIDTH-1:0] cam_field, cmask, wmask, care, status_word;
  logic [ENTRIES-1:0][WIDTH-1:0] words_w;
  logic [ENTRIES-1:0][1:0] types_w;
  logic hit_any, hit_multi;
  logic [AW-1:0] hit_addr;

  cam_host_decode #(.AW(AW)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe_i),
    .wr_ni       (wr_ni),
    .cmd_ni      (cmd_ni),
    .op_i        (data_i[F_OP +: 4]),
    .addr_i      (data_i[F_ADDR +: AW]),
    .type_i      (data_i[F_TYPE +: 2]),
    .ld_key_o    (ld_key),
    .ld_m1_o     (ld_m1),
    .ld_m2_o     (ld_m2),
    .ld_word_o   (ld_word),
    .word_addr_o (word_addr),
    .word_type_o (word_type),
    .search_o    (search),
    .clear_o     (clear),
    .cfg_wr_o    (cfg_wr),
    .rd_stat_o   (rd_stat),
    .rd_data_o   (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csel_q  <= '0;
      wsel_q  <= '0;
      lanes_q <= LW'(LANES);
    end else if (cfg_wr) begin
      csel_q  <= data_i[F_CSEL +: 2];
      wsel_q  <= data_i[F_WSEL +: 2];
      lanes_q <= data_i[F_LANES +: LW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m1_q  <= '0;
      m2_q  <= '0;
      key_q <= '0;
    end else begin
      if (clear) begin
        m1_q <= '0;
        m2_q <= '0;
      end else begin
        if (ld_m1) m1_q <= data_i;
        if (ld_m2) m2_q <= data_i;
      end
      if (ld_key) key_q <= data_i;
    end
  end

  assign lanes_eff = (lanes_q > LW'(LANES)) ? LW'(LANES) : lanes_q;

  // compared field grows from the low lane upward
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cam_field[l*LANE_W +: LANE_W] = {LANE_W{LW'(l) < lanes_eff}};
  end

  always_comb begin
    case (csel_q)
      MSEL_ONE: cmask = m1_q;
      MSEL_TWO: cmask = m2_q;
      default:  cmask = '0;
    endcase
    case (wsel_q)
      MSEL_ONE: wmask = m1_q;
      MSEL_TWO: wmask = m2_q;
      default:  wmask = '0;
    endcase
  end

  assign care = cam_field & ~cmask;

  cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .wr_i      (ld_word),
    .addr_i    (word_addr),
    .type_i    (word_type),
    .data_i    (data_i),
    .protect_i (wmask),
    .words_o   (words_w),
    .types_o   (types_w)
  );

  cam_match #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .AW(AW)) u_match (
    .words_i (words_w),
    .types_i (types_w),
    .key_i   (key_q),
    .care_i  (care),
    .any_o   (hit_any),
    .multi_o (hit_multi),
    .addr_o  (hit_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) go_q <= 1'b0;
    else         go_q <= ~clear & (ld_key | search);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      multi_q <= 1'b0;
      addr_q  <= '0;
      assoc_q <= '0;
    end else if (clear) begin
      match_q <= 1'b0;
      multi_q <= 1'b0;
      addr_q  <= '0;
      assoc_q <= '0;
    end else if (go_q) begin
      match_q <= hit_any;
      multi_q <= hit_multi;
      addr_q  <= hit_any ? hit_addr : '0;
      assoc_q <= hit_any ? (words_w[hit_addr] & ~cam_field) : '0;
    end
  end

  always_comb begin
    status_word            = '0;
    status_word[WIDTH-1]   = match_q;
    status_word[WIDTH-2]   = multi_q;
    status_word[AW-1:0]    = addr_q;
  end

  assign data_o = rd_stat ? status_word : (rd_data ? assoc_q : '0);
endmodule

// File: rtl/cam_chk.sv
module cam_chk
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  parameter int AW      = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    clear,
  input logic                    ld_key,
  input logic                    go_q,
  input logic                    match_q,
  input logic                    multi_q,
  input logic [AW-1:0]           addr_q,
  input logic [WIDTH-1:0]        assoc_q,
  input logic [WIDTH-1:0]        m1_q,
  input logic [WIDTH-1:0]        m2_q,
  input logic [ENTRIES-1:0][1:0] types_w
);
  logic [ENTRIES-1:0][1:0] types_d;
  logic [ENTRIES-1:0][1:0] all_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) types_d <= {ENTRIES{ET_EMPTY}};
    else         types_d <= types_w;
  end

  assign all_empty = {ENTRIES{ET_EMPTY}};

  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_q |-> match_q); // R6

  AST_HIT_IS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_q && !clear) |=> (!match_q || types_d[addr_q] == ET_VALID)); // R3

  AST_KEY_STARTS_SEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_key && !clear) |=> go_q); // R4

  AST_STATUS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!go_q && !clear) |=> $stable({match_q, multi_q, addr_q, assoc_q})); // R10

  AST_CLEAR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> (types_w == all_empty && m1_q == '0 && m2_q == '0 && !match_q)); // R11

  AST_MISS_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_q |-> (assoc_q == '0 && addr_q == '0)); // R9
endmodule

bind masked_cam cam_chk #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clear   (clear),
  .ld_key  (ld_key),
  .go_q    (go_q),
  .match_q (match_q),
  .multi_q (multi_q),
  .addr_q  (addr_q),
  .assoc_q (assoc_q),
  .m1_q    (m1_q),
  .m2_q    (m2_q),
  .types_w (types_w)
);

// File: tb/masked_cam_tb.sv
module masked_cam_tb;
  localparam int CLK_PERIOD = 10;
  localparam int E = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, wr_n = 1'b1, cmd_n = 1'b1;
  logic [63:0] din = '0;
  logic [63:0] dout;
  bit done = 1'b0;

  masked_cam u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .wr_ni(wr_n),
    .cmd_ni(cmd_n), .data_i(din), .data_o(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [63:0] mw [E];
  logic [1:0]  mt [E];
  logic [63:0] m1 = '0, m2 = '0, key = '0;
  logic [1:0]  cs = 0, ws = 0;
  int          lanes = 4;
  logic [63:0] exp_stat = '0, exp_assoc = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host(bit w, bit c, logic [63:0] d);
    @(negedge clk);
    strobe = 1'b1; wr_n = w; cmd_n = c; din = d;
    @(negedge clk);
    strobe = 1'b0; wr_n = 1'b1; cmd_n = 1'b1; din = '0;
  endtask

  task automatic peek(bit c, output logic [63:0] v);
    strobe = 1'b1; wr_n = 1'b1; cmd_n = c;
    #1 v = dout;
    strobe = 1'b0; cmd_n = 1'b1;
  endtask

  function automatic logic [63:0] cmdw(int op, int a = 0, int t = 0, int c = 0,
                                       int w = 0, int ln = 0);
    logic [63:0] d = '0;
    d[3:0] = 4'(op); d[11:8] = 4'(a); d[17:16] = 2'(t);
    d[21:20] = 2'(c); d[23:22] = 2'(w); d[26:24] = 3'(ln);
    return d;
  endfunction

  function automatic logic [63:0] sel_mask(logic [1:0] s);
    return (s == 2'd1) ? m1 : ((s == 2'd2) ? m2 : 64'd0);
  endfunction

  function automatic logic [63:0] field();
    logic [63:0] f = '0;
    int n = (lanes > 4) ? 4 : lanes;
    for (int l = 0; l < n; l++) f[l*16 +: 16] = 16'hffff;
    return f;
  endfunction

  task automatic model_search();
    logic [63:0] care = field() & ~sel_mask(cs);
    int cnt = 0, first = 0;
    for (int i = E - 1; i >= 0; i--)
      if (mt[i] == 2'b00 && ((mw[i] ^ key) & care) == 64'd0) begin
        cnt++; first = i;
      end
    exp_stat = '0; exp_assoc = '0;
    if (cnt > 0) begin
      exp_stat[63] = 1'b1;
      exp_stat[62] = (cnt > 1);
      exp_stat[3:0] = 4'(first);
      exp_assoc = mw[first] & ~field();
    end
  endtask

  task automatic op_key(logic [63:0] d);
    host(0, 0, cmdw(1)); host(0, 1, d); key = d; model_search();
  endtask
  task automatic op_mask(int k, logic [63:0] d);
    host(0, 0, cmdw(k == 1 ? 2 : 3)); host(0, 1, d);
    if (k == 1) m1 = d; else m2 = d;
  endtask
  task automatic op_word(int a, int t, logic [63:0] d);
    logic [63:0] pm = sel_mask(ws);
    host(0, 0, cmdw(4, a, t)); host(0, 1, d);
    mw[a] = (mw[a] & pm) | (d & ~pm); mt[a] = 2'(t);
  endtask
  task automatic op_cfg(int c, int w, int ln);
    host(0, 0, cmdw(7, 0, 0, c, w, ln));
    cs = 2'(c); ws = 2'(w); lanes = ln;
  endtask
  task automatic op_search();
    host(0, 0, cmdw(5)); model_search();
  endtask
  task automatic op_clear();
    host(0, 0, cmdw(6));
    for (int i = 0; i < E; i++) mt[i] = 2'b01;
    m1 = '0; m2 = '0; exp_stat = '0; exp_assoc = '0;
  endtask

  task automatic check_res(string tag);
    logic [63:0] v;
    @(negedge clk);
    peek(0, v); chk({tag, " status"}, v, exp_stat);
    peek(1, v); chk({tag, " assoc"}, v, exp_assoc);
  endtask

  function automatic logic [63:0] rnd_word();
    return {16'($urandom % 2), 16'($urandom % 2), 16'($urandom % 3), 16'($urandom % 3)};
  endfunction

  function automatic logic [63:0] rnd_mask();
    logic [63:0] m;
    for (int l = 0; l < 4; l++) begin
      int k = $urandom % 3;
      m[l*16 +: 16] = (k == 0) ? 16'h0 : ((k == 1) ? 16'hffff : 16'($urandom));
    end
    return m;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, old;
    logic [63:0] kw;
    void'($urandom(32'd4242));
    for (int i = 0; i < E; i++) begin mw[i] = '0; mt[i] = 2'b01; end
    kw = 64'h1234_5678_9abc_0042;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    check_res("R1");
    @(negedge clk); #1 chk("R2 idle output", dout, 64'd0);

    op_key(kw); check_res("R3 all empty");

    // types 00 valid, 01 empty, 10 skip, 11 RAM-only
    op_word(3, 0, kw); op_word(5, 0, kw); op_word(1, 2, kw);
    op_word(2, 1, kw); op_word(0, 3, kw);
    old = exp_stat;
    op_key(kw);
    peek(0, v); chk("R4 before second edge", v, old);
    check_res("R6 lowest of two");
    check_res("R3 skip empty ram ignored");

    op_word(5, 2, kw); op_key(kw); check_res("R6 single hit");

    op_cfg(0, 0, 1);
    op_word(3, 0, {32'hdead_beef, kw[31:0]});
    op_key(kw); check_res("R9 one lane");
    op_cfg(0, 0, 0); op_key(64'd0); check_res("R9 zero lanes");
    op_cfg(0, 0, 7); op_key(kw); check_res("R9 lane clip");

    op_mask(1, 64'hffff_ffff_0000_0000);
    op_cfg(1, 0, 4); op_key(kw); check_res("R7 compare mask");

    op_mask(2, 64'hffff_0000_0000_0000);
    op_cfg(1, 2, 4); op_word(3, 0, 64'd0);
    op_cfg(0, 0, 1); op_key(64'd0); check_res("R8 write mask");

    op_key(64'd0);
    op_word(3, 1, 64'd0);
    check_res("R10 hold after word change");
    op_search(); check_res("R5 rerun");

    op_word(7, 0, 64'd0); op_key(64'd0); check_res("R5 setup");
    op_clear(); check_res("R11 clear");
    op_key(64'd0); check_res("R11 all empty after clear");

    for (int it = 0; it < 400; it++) begin
      int k = $urandom % 10;
      if (k < 4) op_word($urandom % E, ($urandom % 8 < 5) ? 0 : $urandom % 4, rnd_word());
      else if (k == 4) op_mask(1 + $urandom % 2, rnd_mask());
      else if (k == 5) op_cfg($urandom % 4, $urandom % 4, $urandom % 6);
      else if (k < 9) begin
        logic [63:0] d;
        d = ($urandom % 2 == 1) ? mw[$urandom % E] : rnd_word();
        if ($urandom % 3 == 0) d = d ^ (64'd1 << ($urandom % 64));
        op_key(d); check_res("R6 R7 R9 random");
      end else begin
        op_search(); check_res("R5 random");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule